// File: doc/BRIEF.md
# Narrow-Bus Read Adapter with Endianness Control

This block lets a 32-bit internal requester read registers and memory that sit behind a 16-bit asynchronous external data bus. Each accepted request asks for a byte, a halfword or a word. Byte and halfword requests need one bus beat. A word request needs two beats. The lower half is fetched first, with the halfword-select address bit driven low. The upper half follows, with that bit driven high. The adapter drives the external byte address and an active-low read strobe. It samples the returned data and presents the assembled result together with a one-cycle valid pulse.

The bus is natively byte-invariant big-endian. Two configuration inputs set how the returned data is interpreted. One input exchanges the two byte lanes of every beat. This lets a wider peripheral that was wired for word-invariant ordering be read correctly. The other input chooses where the first beat lands when a word is assembled. In the default placement, a stored word comes back with its halfwords exchanged. For example, a stored 0x18101207 is read as 0x12071810. The alternate placement returns the stored value unchanged. Both inputs are captured when a request is accepted.

A request that is misaligned for its size never reaches the bus. Instead it produces a one-cycle error flag.

Top module: `narrow_rd_adapter`

## Requirements
- R1: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the edge after an aligned request is accepted until the cycle that carries its `rsp_valid` pulse; in that cycle it is high again. Requests presented while `req_ready` is low have no effect.
- R2: Every bus beat holds `bus_rd_n` low for exactly STROBE_CYCLES consecutive cycles (default 4). The first of these cycles follows the accepting edge. `bus_data` is captured on the last low cycle only.
- R3: A word request (`req_size` 2'b10 or 2'b11) performs two beats. In the first beat `bus_addr[1]` is 0 and in the second it is 1. Exactly one cycle with `bus_rd_n` high separates the two beats.
- R4: A halfword request (`req_size` 2'b01) performs one beat with `bus_addr[1]` equal to the request address bit 1. It returns the 16-bit lane view zero-extended. With bus halfwords 0x1207 at byte address 0x24 and 0x1810 at 0x26, it returns 0x00001207 and 0x00001810.
- R5: A byte request (`req_size` 2'b00) performs one beat and returns one byte zero-extended into bits [7:0]. Address bit 0 picks the byte: 0 selects bits [7:0] of the lane view and 1 selects bits [15:8].
- R6: When `cfg_lane_swap` is 1 at acceptance, the lane view of each beat is the bus halfword with its bytes exchanged: bus bits [7:0] become view bits [15:8] and bus bits [15:8] become view bits [7:0]. When it is 0, the view equals the bus data.
- R7: When `cfg_first_low` is 0 at acceptance, word assembly places the first beat's view in `rsp_data[31:16]` and the second beat's view in `rsp_data[15:0]`. The example of R4 then returns 0x12071810.
- R8: When `cfg_first_low` is 1 at acceptance, the first beat's view goes to `rsp_data[15:0]` and the second to `rsp_data[31:16]`. The example of R4 then returns 0x18101207.
- R9: `rsp_valid` is a single-cycle pulse in the cycle right after the last strobe cycle of the final beat. `rsp_data` holds the result in that cycle.
- R10: Misaligned requests do not start a bus cycle. A word request is misaligned when address bits [1:0] are not 00, and a halfword request is misaligned when address bit 0 is 1. Such a request raises `rsp_err` for the one cycle after the accepting edge, keeps `bus_rd_n` high and `req_ready` high, and produces no `rsp_valid`.
- R11: After reset, `req_ready` is 1 and `bus_rd_n` is 1, while `rsp_valid` and `rsp_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Adapter can accept a request |
| req_addr | input | ADDR_W | Byte address of the read |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| cfg_lane_swap | input | 1 | Exchange byte lanes of each beat |
| cfg_first_low | input | 1 | First word beat goes to bits [15:0] |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | 32 | Assembled read result |
| rsp_err | output | 1 | One-cycle misalignment flag |
| bus_addr | output | ADDR_W | External byte address, bit 0 always 0 |
| bus_rd_n | output | 1 | External read strobe, active low |
| bus_data | input | 16 | External read data |

## Verification
Several properties are checked on every cycle. `req_ready` must be low while the strobe is active. A strobe may end only right after a sampling cycle. After the first beat of a word there must be exactly one idle cycle. `rsp_valid` must be a single pulse that follows a strobe cycle. An error must come from an accepted request and must not coincide with bus activity or a valid pulse. Some behaviour can only be shown by the bench scenarios, because they compare the bus pattern and the returned data with values computed separately. Those scenarios cover:
- the exact strobe length and halfword-select sequence,
- byte lane selection,
- the effect of each combination of swap and placement settings, including the stored 0x18101207 example,
- configuration inputs changing in the middle of a transfer,
- requests held active while the adapter is busy.

// File: rtl/narrow_rd_pkg.sv
package narrow_rd_pkg;
  localparam int BUS_W  = 16;
  localparam int RESP_W = 32;

  // size encoding: 00 byte, 01 halfword, 1x word
  function automatic logic size_is_word(input logic [1:0] sz);
    return sz[1];
  endfunction

  function automatic logic size_is_half(input logic [1:0] sz);
    return (sz == 2'b01);
  endfunction

  function automatic logic misaligned(input logic [1:0] a, input logic [1:0] sz);
    if (size_is_word(sz)) return (a != 2'b00);
    if (size_is_half(sz)) return a[0];
    return 1'b0;
  endfunction

  // byte-lane exchange applied to one bus beat
  function automatic logic [BUS_W-1:0] lane_view(input logic [BUS_W-1:0] d, input logic swap);
    return swap ? {d[7:0], d[15:8]} : d;
  endfunction

  function automatic logic [RESP_W-1:0] build_result(
    input logic [1:0]       sz,
    input logic             a0,
    input logic             first_low,
    input logic [BUS_W-1:0] first_v,
    input logic [BUS_W-1:0] last_v
  );
    if (size_is_word(sz))
      return first_low ? {last_v, first_v} : {first_v, last_v};
    if (size_is_half(sz))
      return {16'h0000, last_v};
    return {24'h000000, (a0 ? last_v[15:8] : last_v[7:0])};
  endfunction
endpackage

// File: rtl/nra_align_chk.sv
module nra_align_chk
  import narrow_rd_pkg::*;
(
  input  logic [1:0] addr_lo,
  input  logic [1:0] size,
  output logic       bad
);
  assign bad = misaligned(addr_lo, size);
endmodule

// File: rtl/nra_beat_seq.sv
module nra_beat_seq #(
  parameter int STROBE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic two_beats,
  output logic busy,
  output logic bus_rd_n,
  output logic beat_idx,
  output logic beat_sample,
  output logic seq_done
);
  localparam int CW = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(STROBE_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_GAP} seq_state_e;
  seq_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic two_q;
  logic idx_q;

  assign busy        = (state_q != S_IDLE);
  assign bus_rd_n    = (state_q != S_ACT);
  assign beat_idx    = idx_q;
  assign beat_sample = (state_q == S_ACT) && (cnt_q == LAST_CNT);
  assign seq_done    = beat_sample && (idx_q || !two_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      two_q   <= 1'b0;
      idx_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_ACT;
          cnt_q   <= '0;
          idx_q   <= 1'b0;
          two_q   <= two_beats;
        end
        S_ACT: begin
          if (beat_sample) begin
            state_q <= seq_done ? S_IDLE : S_GAP;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_GAP: begin
          state_q <= S_ACT;
          idx_q   <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R2
  strobe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_n) |-> $past(beat_sample));

  // R3
  word_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_sample && !seq_done) |=> bus_rd_n ##1 !bus_rd_n);
endmodule

// File: rtl/nra_assemble.sv
module nra_assemble
  import narrow_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_sample,
  input  logic              seq_done,
  input  logic [1:0]        size_q,
  input  logic              a0_q,
  input  logic              swap_q,
  input  logic              first_low_q,
  input  logic [BUS_W-1:0]  bus_data,
  output logic [RESP_W-1:0] result
);
  logic [BUS_W-1:0] view;
  logic [BUS_W-1:0] first_q;

  assign view = lane_view(bus_data, swap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      result  <= '0;
    end else begin
      if (beat_sample && !seq_done) first_q <= view;
      if (seq_done) result <= build_result(size_q, a0_q, first_low_q, first_q, view);
    end
  end
endmodule

// File: rtl/narrow_rd_adapter.sv
module narrow_rd_adapter
  import narrow_rd_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int STROBE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              cfg_lane_swap,
  input  logic              cfg_first_low,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd_n,
  input  logic [15:0]       bus_data
);
  logic accept, bad, start, busy;
  logic beat_idx, beat_sample, seq_done;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0] size_q;
  logic swap_q, first_low_q;
  logic hsel;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign start     = accept && !bad;

  nra_align_chk u_align (
    .addr_lo (req_addr[1:0]),
    .size    (req_size),
    .bad     (bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      size_q      <= 2'b00;
      swap_q      <= 1'b0;
      first_low_q <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_err     <= 1'b0;
    end else begin
      if (start) begin
        addr_q      <= req_addr;
        size_q      <= req_size;
        swap_q      <= cfg_lane_swap;
        first_low_q <= cfg_first_low;
      end
      rsp_valid <= seq_done;
      rsp_err   <= accept && bad;
    end
  end

  nra_beat_seq #(.STROBE_CYCLES(STROBE_CYCLES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .two_beats   (size_is_word(req_size)),
    .busy        (busy),
    .bus_rd_n    (bus_rd_n),
    .beat_idx    (beat_idx),
    .beat_sample (beat_sample),
    .seq_done    (seq_done)
  );

  assign hsel     = size_is_word(size_q) ? beat_idx : addr_q[1];
  assign bus_addr = {addr_q[ADDR_W-1:2], hsel, 1'b0};

  nra_assemble u_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat_sample (beat_sample),
    .seq_done    (seq_done),
    .size_q      (size_q),
    .a0_q        (addr_q[0]),
    .swap_q      (swap_q),
    .first_low_q (first_low_q),
    .bus_data    (bus_data),
    .result      (rsp_data)
  );

  // R1
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !req_ready);

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!bus_rd_n));

  // R10
  err_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (bus_rd_n && !rsp_valid && req_ready));

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(req_valid && req_ready));
endmodule

// File: tb/narrow_rd_adapter_bench.sv
module narrow_rd_adapter_bench;
  localparam int AW = 24;
  localparam int S  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = 2'b00;
  logic cfg_lane_swap = 1'b0;
  logic cfg_first_low = 1'b0;
  logic req_ready, rsp_valid, rsp_err, bus_rd_n;
  logic [31:0] rsp_data;
  logic [AW-1:0] bus_addr;
  logic [15:0] bus_data;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  narrow_rd_adapter #(.ADDR_W(AW), .STROBE_CYCLES(S)) u_narrow_rd_adapter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .cfg_lane_swap(cfg_lane_swap),
    .cfg_first_low(cfg_first_low), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_data(bus_data)
  );

  // bus model: data is only valid on the final cycle of a strobe
  logic [15:0] mem [0:63];
  int low_run = 0;
  always @(posedge clk) low_run <= bus_rd_n ? 0 : low_run + 1;
  assign bus_data = (!bus_rd_n && low_run == S - 1) ? mem[bus_addr[6:1]] : 16'hA5C3;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic logic [15:0] view_of(input logic [15:0] h, input bit sw);
    logic [15:0] v;
    v[15:8] = sw ? h[7:0]  : h[15:8];
    v[7:0]  = sw ? h[15:8] : h[7:0];
    return v;
  endfunction

  function automatic logic [31:0] expect_val(input logic [7:0] a, input logic [1:0] sz,
                                             input bit sw, input bit ord);
    logic [15:0] lo, hi, v;
    lo = view_of(mem[{a[6:2], 1'b0}], sw);
    hi = view_of(mem[{a[6:2], 1'b1}], sw);
    v  = view_of(mem[a[6:1]], sw);
    if (sz[1]) return ord ? {hi, lo} : {lo, hi};
    if (sz == 2'b01) return {16'h0, v};
    return {24'h0, a[0] ? v[15:8] : v[7:0]};
  endfunction

  function automatic bit is_bad(input logic [7:0] a, input logic [1:0] sz);
    if (sz[1]) return a[1:0] != 2'b00;
    if (sz == 2'b01) return a[0];
    return 1'b0;
  endfunction

  task automatic present(input logic [7:0] a, input logic [1:0] sz, input bit sw, input bit ord);
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(a); req_size = sz;
    cfg_lane_swap = sw; cfg_first_low = ord;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic do_read(input logic [7:0] a, input logic [1:0] sz, input bit sw,
                         input bit ord, input bit hold);
    bit two = sz[1];
    int vcyc = two ? 2 * S + 2 : S + 1;
    bit ok_strobe = 1, ok_hsel = 1, ok_ready = 1, ok_valid = 1, ok_err = 1;
    logic [31:0] exp = expect_val(a, sz, sw, ord);
    present(a, sz, sw, ord);
    @(negedge clk);
    cfg_lane_swap = ~sw; cfg_first_low = ~ord;  // must be ignored (latched)
    if (hold) begin req_addr = AW'(a | 8'h3); req_size = 2'b10; end
    else req_valid = 1'b0;
    for (int i = 1; i <= vcyc; i++) begin
      if (i > 1) @(negedge clk);
      begin
        bit low_exp = (i <= S) || (two && i >= S + 2 && i <= 2 * S + 1);
        bit hs_exp  = two ? (i > S) : a[1];
        if (bus_rd_n !== !low_exp) ok_strobe = 0;
        if (low_exp && bus_addr[1] !== hs_exp) ok_hsel = 0;
        if (low_exp && bus_addr[6:2] !== a[6:2]) ok_hsel = 0;
        if (req_ready !== (i == vcyc)) ok_ready = 0;
        if (rsp_valid !== (i == vcyc)) ok_valid = 0;
        if (rsp_err !== 1'b0) ok_err = 0;
      end
      if (i == vcyc) begin
        chk(rsp_data === exp, sz[1] ? (ord ? "R8 word data" : "R7 word data")
                          : (sz == 2'b01 ? "R4 half data" : "R5 byte data"), rsp_data, exp);
        req_valid = 1'b0;
      end
    end
    chk(ok_strobe, two ? "R3 two-beat strobe pattern" : "R2 strobe length", 32'(ok_strobe), 1);
    chk(ok_hsel, "R3 halfword select address", 32'(ok_hsel), 1);
    chk(ok_ready && ok_err, "R1 ready while busy", 32'(ok_ready && ok_err), 1);
    chk(ok_valid, "R9 valid timing", 32'(ok_valid), 1);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R9 valid single pulse", 32'(rsp_valid), 0);
  endtask

  task automatic do_bad(input logic [7:0] a, input logic [1:0] sz);
    present(a, sz, 1'b0, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_err === 1'b1 && bus_rd_n === 1'b1 && req_ready === 1'b1 && rsp_valid === 1'b0,
        "R10 misaligned error", {rsp_err, bus_rd_n, req_ready, rsp_valid}, 32'hE);
    @(negedge clk);
    chk(rsp_err === 1'b0 && bus_rd_n === 1'b1, "R10 error one cycle", {rsp_err, bus_rd_n}, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual=hung expected=complete");
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(7001);
    for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
    mem[6'h12] = 16'h1207;
    mem[6'h13] = 16'h1810;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready === 1'b1 && bus_rd_n === 1'b1 && rsp_valid === 1'b0 && rsp_err === 1'b0,
        "R11 reset state", {req_ready, bus_rd_n, rsp_valid, rsp_err}, 32'hC);
    rst_n = 1'b1;

    do_read(8'h24, 2'b01, 0, 0, 0);   // R4: 0x1207
    chk(rsp_data === 32'h1207, "R4 offset 0 example", rsp_data, 32'h1207);
    do_read(8'h26, 2'b01, 0, 0, 0);   // R4: 0x1810
    chk(rsp_data === 32'h1810, "R4 offset 2 example", rsp_data, 32'h1810);
    do_read(8'h24, 2'b10, 0, 0, 0);   // R7 corner: halves exchanged
    chk(rsp_data === 32'h12071810, "R7 swapped word example", rsp_data, 32'h12071810);
    do_read(8'h24, 2'b10, 0, 1, 0);   // R8
    chk(rsp_data === 32'h18101207, "R8 stored word example", rsp_data, 32'h18101207);
    do_read(8'h24, 2'b01, 1, 0, 0);   // R6
    chk(rsp_data === 32'h0712, "R6 lane swap half", rsp_data, 32'h0712);
    do_read(8'h25, 2'b00, 0, 0, 0);   // R5
    chk(rsp_data === 32'h12, "R5 upper byte lane", rsp_data, 32'h12);
    do_read(8'h25, 2'b00, 1, 0, 0);   // R5 + R6
    chk(rsp_data === 32'h07, "R5 lane after swap", rsp_data, 32'h07);
    do_read(8'h24, 2'b11, 1, 0, 1);   // R1 held request while busy, R6 word
    chk(rsp_data === 32'h07121018, "R6 swapped word", rsp_data, 32'h07121018);
    do_bad(8'h26, 2'b10);             // R10
    do_bad(8'h25, 2'b01);             // R10
    do_bad(8'h27, 2'b11);             // R10

    for (int n = 0; n < 80; n++) begin
      logic [7:0] a = 8'($urandom % 128);
      logic [1:0] sz = 2'($urandom % 4);
      if ($urandom % 5 != 0) begin
        if (sz[1]) a[1:0] = 2'b00;
        else if (sz == 2'b01) a[0] = 1'b0;
      end
      if (is_bad(a, sz)) do_bad(a, sz);
      else do_read(a, sz, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
    end

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule